// File: doc/BRIEF.md
# Accumulator ALU with Barrel Shifter

A single-cycle 32-bit fixed-point datapath built around one accumulator. Values use the upper half of the word, so a 16-bit register operand enters as `value << 16`. Two operand muxes pick their inputs from four sources:

- the accumulator,
- one of two 16-bit register operands,
- a signed 16x16 multiplier.

One of sixteen ALU functions combines the two operands. Flags come from the raw ALU output. The value then passes through a shift, saturate or carry-rotate stage that a 5-bit code selects.

On each cycle where the execute strobe is high, the shifted value loads into the accumulator and the four flags update. The upper 16 bits of the shifted value are offered on a writeback port in the same cycle, ahead of the load. Operand fetch and instruction sequencing belong to the surrounding engine, which drives the operand and control inputs once per executed instruction.

Top module: `acc_shift_alu`

## Requirements
- R1: Reset (active-low, asynchronous) clears the accumulator and all four flags to zero.
- R2: While `exec` is low, the accumulator and flags keep their values, whatever the other inputs do.
- R3: The operand selects decode as: 0 = accumulator, 1 = `{opr1,16'h0}`, 2 = `{opr2,16'h0}`, 3 = multiplier output.
- R4: The multiplier output is 32 bits.
  - With `prod_sel` = 1 it is `mul1*mul2*2`, signed.
  - With `prod_sel` = 0 it is `mul1` times the accumulator shifted arithmetically right by 15 with bit 0 cleared, signed and truncated to 32 bits.
- R5: The `fn` codes map to these functions:
  - 0 and 8 pass A.
  - 1 gives 0-B.
  - 2 and 3 add.
  - 4 and 5 subtract.
  - 6 gives A+0x1000 and 7 gives A-0x1000.
  - 9 to 15 give, in order: NOT A, AND, NAND, OR, NOR, XOR, XNOR.
- R6: Carry and overflow:
  - Codes 1 to 7 set carry to the bit-32 carry-out. For subtraction this carry means "no borrow".
  - Codes 1 to 7 set overflow by the two's-complement rule on bit 31.
  - Codes 0 and 8 to 15 clear both carry and overflow.
- R7: Carry-propagate codes 3 and 5:
  - B is forced to `carry << 16`.
  - If A selects the multiplier with `prod_sel` = 0, A becomes `{mul1,16'h0}` when carry is set and 0 otherwise.
- R8: Zero is set when bits 31:16 of the ALU output are all zero. Negative is bit 31 of the ALU output. Both are taken before the shift stage.
- R9: The shift code is `{fn[3], shf}`. Codes 1 to 5 and 17 to 21 shift left by 1 to 5. Codes 6 and 22 shift left by 8. Codes 0 and 16 pass the value unchanged.
- R10: Codes 9 to 15 shift arithmetically right by 16, 8, 5, 4, 3, 2 and 1. Codes 25 to 31 shift logically right by the same amounts.
- R11: Codes 7 and 23 saturate when overflow is set: the value becomes 0x7FFFF000 if negative is set, else 0x80000000. Without overflow the value passes unchanged.
- R12: Codes 8 and 24 perform a carry rotate:
  - Carry becomes old bit 31.
  - Bits 31:17 take old bits 30:16.
  - Bit 16 takes the new carry.
  - Bits 15:12 are kept and bits 11:0 are cleared.
- R13: `wb_data` shows bits 31:16 of the shifted value in the same cycle. That shifted value is what loads into the accumulator on an executed edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec | input | 1 | Execute strobe; loads accumulator and flags |
| sel_a | input | 2 | Operand A source |
| sel_b | input | 2 | Operand B source |
| fn | input | 4 | ALU function; bit 3 also forms shift-code bit 4 |
| shf | input | 4 | Shift field, low four bits of the shift code |
| prod_sel | input | 1 | Multiplier second factor: 1 = mul2, 0 = scaled accumulator |
| opr1 | input | 16 | First register operand |
| opr2 | input | 16 | Second register operand |
| mul1 | input | 16 | Multiplier first factor |
| mul2 | input | 16 | Multiplier second factor |
| acc | output | 32 | Accumulator |
| wb_data | output | 16 | Upper half of the current shifted result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The ALU's carry/overflow generation and the shift stage's carry rotate can both act in the same cycle, and both write the carry flag. The bench provokes this by issuing increment and pass codes together with shift field 8, then compares the new carry with the rotated-out bit 31 rather than with the adder carry-out. In a similar way, a subtract that overflows is paired with shift field 7. Here the saturated value must follow the sign of the raw, unshifted result, and the overflow and carry flags must still report the adder outcome.

// File: rtl/acc_shift_alu.sv
module acc_shift_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exec,
  input  logic [1:0]  sel_a,
  input  logic [1:0]  sel_b,
  input  logic [3:0]  fn,
  input  logic [3:0]  shf,
  input  logic        prod_sel,
  input  logic [15:0] opr1,
  input  logic [15:0] opr2,
  input  logic [15:0] mul1,
  input  logic [15:0] mul2,
  output logic [31:0] acc,
  output logic [15:0] wb_data,
  output logic        flag_z,
  output logic        flag_n,
  output logic        flag_c,
  output logic        flag_v
);

  logic               cprop;
  logic [31:0]        acc_s;
  logic signed [31:0] m1_x, m2_x, p_pair, p_acc;
  logic [31:0]        mult_out, a_mult, opa, opb;
  logic [31:0]        x, yv, alu_y, sh_y;
  logic               sub, arith, ov;
  logic [32:0]        sum;
  logic               pre_c, pre_v;
  logic               next_c;
  logic [4:0]         lamt, ramt;

  assign cprop  = (fn == 4'd3) || (fn == 4'd5);
  assign acc_s  = {{15{acc[31]}}, acc[31:16], 1'b0};
  assign m1_x   = $signed({{16{mul1[15]}}, mul1});
  assign m2_x   = $signed({{16{mul2[15]}}, mul2});
  assign p_pair = m1_x * m2_x;
  assign p_acc  = m1_x * $signed(acc_s);

  assign mult_out = prod_sel ? {p_pair[30:0], 1'b0} : p_acc;
  assign a_mult   = (prod_sel || !cprop) ? mult_out
                  : (flag_c ? {mul1, 16'h0} : 32'h0);

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] m,
                                       input logic [31:0] a, input logic [15:0] r1,
                                       input logic [15:0] r2);
    case (s)
      2'd0:    pick = a;
      2'd1:    pick = {r1, 16'h0};
      2'd2:    pick = {r2, 16'h0};
      default: pick = m;
    endcase
  endfunction

  assign opa = pick(sel_a, a_mult, acc, opr1, opr2);
  assign opb = cprop ? {15'h0, flag_c, 16'h0}
                     : pick(sel_b, mult_out, acc, opr1, opr2);

  always_comb begin
    x = opa; yv = opb; sub = 1'b0; arith = 1'b1;
    case (fn)
      4'd1:       begin x = 32'h0; sub = 1'b1; end
      4'd2, 4'd3: sub = 1'b0;
      4'd4, 4'd5: sub = 1'b1;
      4'd6:       yv = 32'h0000_1000;
      4'd7:       begin yv = 32'h0000_1000; sub = 1'b1; end
      default:    arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, sub ? ~yv : yv} + {32'h0, sub};
  assign ov  = sub ? ((x[31] != yv[31]) && (sum[31] != x[31]))
                   : ((x[31] == yv[31]) && (sum[31] != x[31]));

  always_comb begin
    case (fn)
      4'd9:    alu_y = ~opa;
      4'd10:   alu_y = opa & opb;
      4'd11:   alu_y = ~(opa & opb);
      4'd12:   alu_y = opa | opb;
      4'd13:   alu_y = ~(opa | opb);
      4'd14:   alu_y = opa ^ opb;
      4'd15:   alu_y = ~(opa ^ opb);
      default: alu_y = arith ? sum[31:0] : opa;
    endcase
  end

  assign pre_c = arith && sum[32];
  assign pre_v = arith && ov;

  always_comb begin
    case (shf)
      4'd6:    lamt = 5'd8;
      default: lamt = {2'b0, shf[2:0]};
    endcase
    case (shf)
      4'd9:    ramt = 5'd16;
      4'd10:   ramt = 5'd8;
      4'd11:   ramt = 5'd5;
      default: ramt = 5'd16 - {1'b0, shf};
    endcase
  end

  always_comb begin
    sh_y   = alu_y;
    next_c = pre_c;
    if (shf >= 4'd1 && shf <= 4'd6)
      sh_y = alu_y << lamt;
    else if (shf == 4'd7) begin
      if (pre_v) sh_y = alu_y[31] ? 32'h7FFF_F000 : 32'h8000_0000;
    end else if (shf == 4'd8) begin
      next_c = alu_y[31];
      sh_y   = {alu_y[30:16], alu_y[31], alu_y[15:12], 12'h0};
    end else if (shf >= 4'd9)
      sh_y = fn[3] ? (alu_y >> ramt) : 32'($signed(alu_y) >>> ramt);
  end

  assign wb_data = sh_y[31:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= 32'h0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else if (exec) begin
      acc    <= sh_y;
      flag_z <= (alu_y[31:16] == 16'h0);
      flag_n <= alu_y[31];
      flag_c <= next_c;
      flag_v <= pre_v;
    end
  end

endmodule

module acc_shift_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exec,
  input logic [3:0]  fn,
  input logic [3:0]  shf,
  input logic [31:0] acc,
  input logic [15:0] wb_data,
  input logic        flag_z,
  input logic        flag_n,
  input logic        flag_c,
  input logic        flag_v
);

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(acc) && $stable({flag_z, flag_n, flag_c, flag_v})); // R2

  AST_WB_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> acc[31:16] == $past(wb_data)); // R13

  AST_LOGIC_CLEARS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    exec && fn[3] && shf != 4'd8 |=> !flag_c && !flag_v); // R6

  AST_CLIP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    exec && shf == 4'd7 |=> !flag_v || acc == 32'h7FFF_F000 || acc == 32'h8000_0000); // R11

  AST_ROTATE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    exec && shf == 4'd8 |=> acc[16] == flag_c); // R12

  AST_FLAGS_UNSHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
    exec && shf == 4'd0 |=> flag_z == (acc[31:16] == 16'h0) && flag_n == acc[31]); // R8

endmodule

bind acc_shift_alu acc_shift_alu_chk u_chk (.*);

// File: tb/test_acc_shift_alu.sv
module test_acc_shift_alu;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, exec = 1'b0;
  logic [1:0]  sel_a = '0, sel_b = '0;
  logic [3:0]  fn = '0, shf = '0;
  logic        prod_sel = 1'b0;
  logic [15:0] opr1 = '0, opr2 = '0, mul1 = '0, mul2 = '0;
  logic [31:0] acc;
  logic [15:0] wb_data;
  logic        flag_z, flag_n, flag_c, flag_v;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  acc_shift_alu i_acc_shift_alu (.*);

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  sa, sb;
    logic [3:0]  f, s;
    logic        ps;
    logic [15:0] o1, o2, m1, m2;
    logic [31:0] ex;
    logic [3:0]  fl;   // {z,n,c,v}
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  2'd1,2'd0,4'h0,4'h0,1'b0,16'h1234,16'h0000,16'h0000,16'h0000,32'h12340000,4'b0000}, // R3
    '{4'd6,  2'd1,2'd2,4'h2,4'h0,1'b0,16'h7000,16'h2000,16'h0000,16'h0000,32'h90000000,4'b0101}, // R6
    '{4'd5,  2'd1,2'd2,4'h4,4'h0,1'b0,16'h0001,16'h0002,16'h0000,16'h0000,32'hFFFF0000,4'b0100}, // R5
    '{4'd3,  2'd0,2'd0,4'h1,4'h0,1'b0,16'h0000,16'h0000,16'h0000,16'h0000,32'h00010000,4'b0000}, // R3
    '{4'd5,  2'd1,2'd0,4'h6,4'h0,1'b0,16'h0000,16'h0000,16'h0000,16'h0000,32'h00001000,4'b1000}, // R5
    '{4'd6,  2'd0,2'd0,4'h7,4'h0,1'b0,16'h0000,16'h0000,16'h0000,16'h0000,32'h00000000,4'b1010}, // R6
    '{4'd5,  2'd1,2'd2,4'hA,4'h0,1'b0,16'hF0F0,16'hFF00,16'h0000,16'h0000,32'hF0000000,4'b0100}, // R5
    '{4'd5,  2'd1,2'd2,4'hD,4'h0,1'b0,16'h00FF,16'h0F00,16'h0000,16'h0000,32'hF000FFFF,4'b0100}, // R5
    '{4'd5,  2'd1,2'd2,4'hF,4'h0,1'b0,16'h1234,16'h1234,16'h0000,16'h0000,32'hFFFFFFFF,4'b0100}, // R5
    '{4'd8,  2'd1,2'd0,4'h9,4'h0,1'b0,16'hFFFF,16'h0000,16'h0000,16'h0000,32'h0000FFFF,4'b1000}, // R8
    '{4'd5,  2'd1,2'd2,4'hB,4'h0,1'b0,16'hFFFF,16'h8000,16'h0000,16'h0000,32'h7FFFFFFF,4'b0000}, // R5
    '{4'd5,  2'd1,2'd2,4'hC,4'h0,1'b0,16'h0001,16'h0100,16'h0000,16'h0000,32'h01010000,4'b0000}, // R5
    '{4'd5,  2'd1,2'd2,4'hE,4'h0,1'b0,16'hFF00,16'h0FF0,16'h0000,16'h0000,32'hF0F00000,4'b0100}, // R5
    '{4'd4,  2'd3,2'd0,4'h0,4'h0,1'b1,16'h0000,16'h0000,16'h0003,16'hFFFE,32'hFFFFFFF4,4'b0100}, // R4
    '{4'd4,  2'd3,2'd0,4'h0,4'h0,1'b0,16'h0000,16'h0000,16'h0005,16'h0000,32'hFFFFFFF6,4'b0100}, // R4
    '{4'd3,  2'd1,2'd0,4'h0,4'h0,1'b0,16'h4000,16'h0000,16'h0000,16'h0000,32'h40000000,4'b0000}, // R3
    '{4'd4,  2'd3,2'd0,4'h0,4'h0,1'b0,16'h0000,16'h0000,16'h0010,16'h0000,32'h00080000,4'b0000}, // R4
    '{4'd4,  2'd1,2'd3,4'h2,4'h0,1'b1,16'h0001,16'h0000,16'h0100,16'h0100,32'h00030000,4'b0000}, // R4
    '{4'd9,  2'd1,2'd0,4'h0,4'h1,1'b0,16'h0001,16'h0000,16'h0000,16'h0000,32'h00020000,4'b0000}, // R9
    '{4'd9,  2'd1,2'd0,4'h8,4'h6,1'b0,16'h00AB,16'h0000,16'h0000,16'h0000,32'hAB000000,4'b0000}, // R9
    '{4'd10, 2'd1,2'd0,4'h0,4'h9,1'b0,16'h8000,16'h0000,16'h0000,16'h0000,32'hFFFF8000,4'b0100}, // R10
    '{4'd10, 2'd1,2'd0,4'h8,4'h9,1'b0,16'h8000,16'h0000,16'h0000,16'h0000,32'h00008000,4'b0100}, // R10
    '{4'd10, 2'd1,2'd0,4'h0,4'hB,1'b0,16'hF000,16'h0000,16'h0000,16'h0000,32'hFF800000,4'b0100}, // R10
    '{4'd10, 2'd1,2'd0,4'h8,4'hF,1'b0,16'hF000,16'h0000,16'h0000,16'h0000,32'h78000000,4'b0100}, // R10
    '{4'd10, 2'd1,2'd0,4'h8,4'hC,1'b0,16'h1230,16'h0000,16'h0000,16'h0000,32'h01230000,4'b0000}, // R10
    '{4'd10, 2'd1,2'd0,4'h0,4'hA,1'b0,16'h9000,16'h0000,16'h0000,16'h0000,32'hFF900000,4'b0100}, // R10
    '{4'd11, 2'd1,2'd2,4'h2,4'h7,1'b0,16'h7000,16'h2000,16'h0000,16'h0000,32'h7FFFF000,4'b0101}, // R11
    '{4'd11, 2'd1,2'd2,4'h4,4'h7,1'b0,16'h8000,16'h0001,16'h0000,16'h0000,32'h80000000,4'b0011}, // R11
    '{4'd11, 2'd1,2'd2,4'h2,4'h7,1'b0,16'h0001,16'h0001,16'h0000,16'h0000,32'h00020000,4'b0000}, // R11
    '{4'd11, 2'd1,2'd2,4'hC,4'h7,1'b0,16'h0005,16'h0000,16'h0000,16'h0000,32'h00050000,4'b0000}, // R11
    '{4'd12, 2'd1,2'd0,4'h0,4'h8,1'b0,16'h8001,16'h0000,16'h0000,16'h0000,32'h00030000,4'b0110}, // R12
    '{4'd12, 2'd1,2'd0,4'h6,4'h8,1'b0,16'h4000,16'h0000,16'h0000,16'h0000,32'h80001000,4'b0000}, // R12
    '{4'd12, 2'd1,2'd0,4'h8,4'h8,1'b0,16'h0001,16'h0000,16'h0000,16'h0000,32'h00020000,4'b0000}, // R12
    '{4'd6,  2'd1,2'd2,4'h4,4'h0,1'b0,16'h0005,16'h0003,16'h0000,16'h0000,32'h00020000,4'b0010}, // R6
    '{4'd7,  2'd1,2'd0,4'h3,4'h0,1'b0,16'h0010,16'h0000,16'h0000,16'h0000,32'h00110000,4'b0000}, // R7
    '{4'd7,  2'd1,2'd0,4'h5,4'h0,1'b0,16'h0010,16'h0000,16'h0000,16'h0000,32'h00100000,4'b0010}, // R7
    '{4'd7,  2'd3,2'd0,4'h3,4'h0,1'b0,16'h0000,16'h0000,16'h0007,16'h0000,32'h00080000,4'b0000}, // R7
    '{4'd7,  2'd3,2'd0,4'h5,4'h0,1'b0,16'h0000,16'h0000,16'h0007,16'h0000,32'h00000000,4'b1010}, // R7
    '{4'd7,  2'd3,2'd0,4'h5,4'h0,1'b1,16'h0000,16'h0000,16'h0002,16'h0003,32'hFFFF000C,4'b0100}, // R7
    '{4'd6,  2'd1,2'd2,4'h2,4'h0,1'b0,16'hFFFF,16'h0001,16'h0000,16'h0000,32'h00000000,4'b1010}  // R6
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset acc", acc, 32'h0);
    chk("R1 reset flags", {28'h0, flag_z, flag_n, flag_c, flag_v}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel_a = VEC[i].sa; sel_b = VEC[i].sb; fn = VEC[i].f; shf = VEC[i].s;
      prod_sel = VEC[i].ps; opr1 = VEC[i].o1; opr2 = VEC[i].o2;
      mul1 = VEC[i].m1; mul2 = VEC[i].m2; exec = 1'b1;
      #1;
      chk($sformatf("R13 vec %0d wb (R%0d)", i, VEC[i].rq), {16'h0, wb_data}, {16'h0, VEC[i].ex[31:16]});
      @(posedge clk); #1;
      exec = 1'b0;
      chk($sformatf("R%0d vec %0d acc", VEC[i].rq, i), acc, VEC[i].ex);
      chk($sformatf("R%0d vec %0d flags zncv", VEC[i].rq, i),
          {28'h0, flag_z, flag_n, flag_c, flag_v}, {28'h0, VEC[i].fl});
    end

    // R2: inputs change with exec low; nothing moves
    @(negedge clk);
    sel_a = 2'd1; fn = 4'h2; shf = 4'h8; opr1 = 16'h5555;
    repeat (2) @(posedge clk);
    #1;
    chk("R2 hold acc", acc, 32'h0);
    chk("R2 hold flags", {28'h0, flag_z, flag_n, flag_c, flag_v}, 32'hA);

    // load a nonzero value, then reset mid-run (R1)
    @(negedge clk);
    fn = 4'h0; shf = 4'h0; exec = 1'b1;
    @(posedge clk); #1;
    exec = 1'b0;
    chk("R3 load before reset", acc, 32'h5555_0000);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1 async reset acc", acc, 32'h0);
    chk("R1 async reset flags", {28'h0, flag_z, flag_n, flag_c, flag_v}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule